// File: doc/BRIEF.md
# Platform Reset Control Port

This block is a single byte-wide control register that is decoded at one I/O port address, 0xCF9 by default. Software writes a byte to the port to request a restart of the machine. The block keeps every byte that is written, and a read of the port returns that byte.

One bit of the byte, the request bit, starts a reset. A reset is issued only when a write moves that bit from 0 to 1. A second bit, the kind-select bit, chooses between two outputs. One output is a hard reset pulse, which restarts the whole platform. The other is a soft reset pulse, which restarts only the processor. Each pulse lasts exactly one clock cycle. The rest of the system takes these pulses and handles the actual reset sequencing.

Top module: `platform_reset_port`

## Requirements
- R1: After the block's own reset (active-low `rst_n`), the stored byte is 0x00 and both pulse outputs are low.
- R2: A write (`io_wr` high) to the decoded port stores all eight bits of `io_wdata` at the clock edge. From then on, a read (`io_rd` high) of that port returns the stored byte on `io_rdata` in the same cycle.
- R3: A write to any other address leaves the stored byte unchanged.
- R4: When no read of the decoded port is taking place (`io_rd` low, or a different address), `io_rdata` is 0x00.
- R5: Take a write to the port in which bit 2 (the request bit) is 1 while the stored bit 2 is 0, and bit 1 (the kind-select bit) is 1. It raises `hard_rst_pulse` for exactly the one cycle after the write edge, and `soft_rst_pulse` stays low.
- R6: Take the same transition with bit 1 equal to 0. It raises `soft_rst_pulse` for exactly one cycle after the write edge, and `hard_rst_pulse` stays low.
- R7: A write with bit 2 set while the stored bit 2 is already 1 issues no pulse, whatever the value of bit 1.
- R8: A write with bit 2 clear issues no pulse. At most one pulse output is high in any cycle, and no pulse lasts longer than one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset for the block |
| io_addr | input | 16 | I/O address |
| io_wr | input | 1 | Write strobe, one cycle for each write |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe |
| io_rdata | output | 8 | Read data: the stored byte when the decoded port is read, otherwise 0x00 |
| hard_rst_pulse | output | 1 | One-cycle request for a full platform reset |
| soft_rst_pulse | output | 1 | One-cycle request for a processor-only reset |

## Verification
The bench builds the block with its default parameters: a 16-bit address, the port at 0xCF9, a full-address match, the request bit at position 2 and the kind-select bit at position 1. Because the match is exact, an address that differs from 0xCF9 in one bit counts as a miss. This lets directed writes to 0xCF8 and 0xCFB check R3 and R4. Random bytes written with a bias toward the port drive the request bit through all four old/new combinations, with both kind-select values, so every pulse case is reached many times.

// File: rtl/rstport_pkg.sv
package rstport_pkg;

   typedef enum logic [1:0] {
      RK_NONE = 2'd0,
      RK_SOFT = 2'd1,
      RK_HARD = 2'd2
   } rst_kind_e;

   function automatic rst_kind_e classify(input logic req_old,
                                          input logic req_new,
                                          input logic sel_new);
      if (req_new && !req_old)
         return sel_new ? RK_HARD : RK_SOFT;
      return RK_NONE;
   endfunction

endpackage

// File: rtl/rstport_decode.sv
module rstport_decode #(
   parameter int              ADDR_W     = 16,
   parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'hCF9,
   parameter logic [ADDR_W-1:0] MATCH_MASK = '1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr,
   input  logic              rd,
   output logic              wr_hit,
   output logic              rd_hit
);
   localparam logic [ADDR_W-1:0] FULL_MASK = '1;
   localparam bit                EXACT     = (MATCH_MASK == FULL_MASK);

   logic match;

   generate
      if (EXACT) begin : g_exact
         assign match = (addr == PORT_ADDR);
      end else begin : g_masked
         assign match = ((addr & MATCH_MASK) == (PORT_ADDR & MATCH_MASK));
      end
   endgenerate

   assign wr_hit = wr & match;
   assign rd_hit = rd & match;
endmodule

// File: rtl/rstport_store.sv
module rstport_store #(
   parameter int               DATA_W    = 8,
   parameter logic [DATA_W-1:0] RESET_VAL = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         q <= RESET_VAL;
      else if (load)
         q <= d;
   end

   AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(q)); // R3
endmodule

// File: rtl/rstport_pulse.sv
module rstport_pulse
   import rstport_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic fire,
   input  logic req_old,
   input  logic req_new,
   input  logic sel_new,
   output logic hard_pulse,
   output logic soft_pulse
);
   rst_kind_e kind;

   always_comb begin
      kind = fire ? classify(req_old, req_new, sel_new) : RK_NONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hard_pulse <= 1'b0;
         soft_pulse <= 1'b0;
      end else begin
         hard_pulse <= (kind == RK_HARD);
         soft_pulse <= (kind == RK_SOFT);
      end
   end

   AST_ONE_PULSE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hard_pulse, soft_pulse})); // R8
   AST_HARD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      hard_pulse |=> !hard_pulse); // R5
   AST_SOFT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_pulse |=> !soft_pulse); // R6
endmodule

// File: rtl/platform_reset_port.sv
module platform_reset_port #(
   parameter int                ADDR_W     = 16,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] PORT_ADDR  = 16'hCF9,
   parameter logic [ADDR_W-1:0] MATCH_MASK = '1,
   parameter int                REQ_BIT    = 2,
   parameter int                SEL_BIT    = 1,
   parameter logic [DATA_W-1:0] RESET_VAL  = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] io_addr,
   input  logic              io_wr,
   input  logic [DATA_W-1:0] io_wdata,
   input  logic              io_rd,
   output logic [DATA_W-1:0] io_rdata,
   output logic              hard_rst_pulse,
   output logic              soft_rst_pulse
);
   localparam logic [DATA_W-1:0] IDLE_READ = '0;

   generate
      if (REQ_BIT < 0 || REQ_BIT >= DATA_W) begin : g_bad_req
         $error("REQ_BIT outside the data word");
      end
      if (SEL_BIT < 0 || SEL_BIT >= DATA_W) begin : g_bad_sel
         $error("SEL_BIT outside the data word");
      end
      if (REQ_BIT == SEL_BIT) begin : g_bad_overlap
         $error("REQ_BIT and SEL_BIT must differ");
      end
      if (ADDR_W < 1 || DATA_W < 2) begin : g_bad_width
         $error("address or data width too small");
      end
   endgenerate

   logic              wr_hit;
   logic              rd_hit;
   logic [DATA_W-1:0] stored;

   rstport_decode #(
      .ADDR_W    (ADDR_W),
      .PORT_ADDR (PORT_ADDR),
      .MATCH_MASK(MATCH_MASK)
   ) u_decode (
      .addr  (io_addr),
      .wr    (io_wr),
      .rd    (io_rd),
      .wr_hit(wr_hit),
      .rd_hit(rd_hit)
   );

   rstport_store #(
      .DATA_W   (DATA_W),
      .RESET_VAL(RESET_VAL)
   ) u_store (
      .clk  (clk),
      .rst_n(rst_n),
      .load (wr_hit),
      .d    (io_wdata),
      .q    (stored)
   );

   rstport_pulse u_pulse (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (wr_hit),
      .req_old   (stored[REQ_BIT]),
      .req_new   (io_wdata[REQ_BIT]),
      .sel_new   (io_wdata[SEL_BIT]),
      .hard_pulse(hard_rst_pulse),
      .soft_pulse(soft_rst_pulse)
   );

   assign io_rdata = rd_hit ? stored : IDLE_READ;

   AST_HARD_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      hard_rst_pulse |-> (stored[REQ_BIT] && !$past(stored[REQ_BIT]) && stored[SEL_BIT])); // R5
   AST_SOFT_ON_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst_pulse |-> (stored[REQ_BIT] && !$past(stored[REQ_BIT]) && !stored[SEL_BIT])); // R6
   AST_NO_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
      (stored[REQ_BIT] && $stable(stored[REQ_BIT])) |-> !(hard_rst_pulse || soft_rst_pulse)); // R7
   AST_IDLE_READ: assert property (@(posedge clk) disable iff (!rst_n)
      !io_rd |-> (io_rdata == IDLE_READ)); // R4
endmodule

// File: tb/platform_reset_port_test.sv
module platform_reset_port_test;
   localparam logic [15:0] PORT = 16'hCF9;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_wr = 1'b0;
   logic [7:0]  io_wdata = '0;
   logic        io_rd = 1'b0;
   logic [7:0]  io_rdata;
   logic        hard_rst_pulse;
   logic        soft_rst_pulse;

   int checks = 0;
   int failures = 0;
   logic [7:0] model = 8'h00;
   bit done = 1'b0;

   always #2 clk = ~clk;

   platform_reset_port uut (
      .clk           (clk),
      .rst_n         (rst_n),
      .io_addr       (io_addr),
      .io_wr         (io_wr),
      .io_wdata      (io_wdata),
      .io_rd         (io_rd),
      .io_rdata      (io_rdata),
      .hard_rst_pulse(hard_rst_pulse),
      .soft_rst_pulse(soft_rst_pulse)
   );

   function automatic logic [1:0] exp_pulses(input logic [7:0] old_v, input logic [7:0] new_v);
      // {hard, soft}
      if (new_v[2] && !old_v[2])
         return new_v[1] ? 2'b10 : 2'b01;
      return 2'b00;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic do_read(input logic [15:0] a, input string req);
      @(negedge clk);
      io_addr = a;
      io_rd = 1'b1;
      #1;
      check(req, {8'h00, io_rdata}, (a == PORT) ? {8'h00, model} : 16'h0000);
      io_rd = 1'b0;
   endtask

   task automatic do_write(input logic [15:0] a, input logic [7:0] d, input string req);
      logic [1:0] exp;
      exp = (a == PORT) ? exp_pulses(model, d) : 2'b00;
      @(negedge clk);
      io_addr = a;
      io_wdata = d;
      io_wr = 1'b1;
      @(negedge clk);
      io_wr = 1'b0;
      if (a == PORT) model = d;
      check(req, {14'd0, hard_rst_pulse, soft_rst_pulse}, {14'd0, exp});
      @(negedge clk);
      check("R8 pulse width", {14'd0, hard_rst_pulse, soft_rst_pulse}, 16'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5eed_0cf9));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1 pulses", {14'd0, hard_rst_pulse, soft_rst_pulse}, 16'd0);
      do_read(PORT, "R1 reset value");
      // R2 store/readback
      do_write(PORT, 8'hA9, "R2 write no edge");
      do_read(PORT, "R2 readback");
      do_write(PORT, 8'h00, "R8 clear no pulse");
      // R5 hard
      do_write(PORT, 8'h06, "R5 hard pulse");
      do_read(PORT, "R2 readback 06");
      // R7 repeat set
      do_write(PORT, 8'h06, "R7 repeat hard");
      do_write(PORT, 8'hF4, "R7 repeat soft-kind");
      // R8 clear then R6 soft
      do_write(PORT, 8'hFB, "R8 bit2 clear");
      do_write(PORT, 8'h04, "R6 soft pulse");
      // R3 / R4 other addresses
      do_write(16'hCF8, 8'h00, "R3 miss write");
      do_read(PORT, "R3 unchanged");
      do_write(16'hCFB, 8'h5A, "R3 miss write 2");
      do_read(PORT, "R3 unchanged 2");
      do_read(16'hCF8, "R4 miss read");
      @(negedge clk);
      io_addr = PORT;
      #1;
      check("R4 no strobe", {8'h00, io_rdata}, 16'h0000);
      // random phase
      for (int i = 0; i < 400; i++) begin
         logic [15:0] a;
         logic [7:0] d;
         a = ($urandom % 4 != 0) ? PORT : 16'($urandom);
         d = 8'($urandom);
         if ($urandom % 2 == 0) do_write(a, d, "R5/R6/R7 random write");
         else do_read(a, "R2/R4 random read");
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule